// File: doc/BRIEF.md
# Dual-Bank Pointer Address Generator

This block turns a pointer-register reference into a data RAM address for a small signal processor with two 256-word data RAM banks. It holds eight 8-bit pointers. The lower four pointers serve bank 0 and the upper four serve bank 1. An operand access names a pointer and a 2-bit modifier field. One cycle later the block presents the bank select and the word address that the pointer holds. The same access can step the pointer up or down, and the step wraps within 8 bits.

In each bank, the pointer with the highest index is tied to the bank base and cannot be written. For these two pointers the modifier field is read as a word offset of 0 to 3. The block does not use it as a step. The other six pointers can be loaded from an immediate operand through a separate load port.

The address feeds both direct operand modes and the first level of indirection. This block has no RAM arrays and does not fetch through a RAM word.

Top module: `ptr_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, `addrValid` is 0, and all six writable pointers hold 0.
- R2: `addrValid` is 1 in exactly the cycle after a cycle with `opValid` high, and 0 after any cycle with `opValid` low.
- R3: `addrBank` equals bit 2 of the accessed pointer index. Indices 0–3 select bank 0 and indices 4–7 select bank 1.
- R4: A load through `ldValid`/`ldIdx`/`ldData` to pointer 0, 1, 2, 4, 5 or 6 replaces that pointer's value. The new value is the address returned by the next access to that pointer.
- R5: For a writable pointer, `addrOut` is the pointer's value before modification. The modifier field `opMod` then updates the pointer: 2'b00 leaves it unchanged, 2'b01 adds 1, 2'b10 subtracts 1, and 2'b11 adds 1.
- R6: Post-modification wraps within 8 bits: 8'hFF plus 1 gives 8'h00, and 8'h00 minus 1 gives 8'hFF.
- R7: An access to pointer 3 or 7 returns `addrOut` equal to `opMod` zero-extended to 8 bits, so it selects bank word 0 to 3. The access never changes any pointer.
- R8: A load to pointer 3 or 7 has no effect. A later access to that pointer still returns only the offset.
- R9: When a load and an access target the same writable pointer in one cycle, the access returns the value held before that cycle. The loaded value replaces any post-modification.
- R10: When a load and an access target different pointers in one cycle, both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Operand access request this cycle |
| opPtrIdx | input | 3 | Pointer index of the access |
| opMod | input | 2 | Post-modifier (writable pointers) or word offset (pointers 3 and 7) |
| ldValid | input | 1 | Immediate load request this cycle |
| ldIdx | input | 3 | Pointer index to load |
| ldData | input | 8 | Immediate value to load |
| addrValid | output | 1 | Address outputs hold the result of the previous cycle's access |
| addrBank | output | 1 | Bank select for the address: 0 or 1 |
| addrOut | output | 8 | Word address within the selected bank |

## Verification
The assertions assume that `opPtrIdx` and `opMod` are known in every cycle in which `opValid` is high, and that `ldIdx` and `ldData` are known whenever `ldValid` is high. They also assume these inputs are stable around the rising clock edge. The stimulus changes every input only on the falling edge and sets every field to a defined value even in idle cycles, so both assumptions hold throughout the run. The sweep goes through every pointer index with every modifier code, over values that include both wrap points. It also applies loads aimed at the fixed pointers and same-cycle load/access pairs on the same pointer and on different pointers.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;

  localparam int NUM_PTRS = 8;
  localparam int PTR_W    = 8;
  localparam int MOD_W    = 2;
  localparam int OFS_W    = 2;
  localparam int NUM_BANKS = 2;
  localparam int IDX_W    = $clog2(NUM_PTRS);
  localparam int PER_BANK = NUM_PTRS / NUM_BANKS;
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  typedef enum logic [MOD_W-1:0] {
    MOD_HOLD    = 2'b00,
    MOD_STEP_UP = 2'b01,
    MOD_STEP_DN = 2'b10,
    MOD_STEP_UP2 = 2'b11
  } ptr_mod_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_PTRS-1:0] loadEn;
    logic [NUM_PTRS-1:0] incEn;
    logic [NUM_PTRS-1:0] decEn;
    logic                issue;
    logic                useOffset;
    logic [IDX_W-1:0]    selIdx;
    logic [OFS_W-1:0]    offset;
  } agu_ctl_t;

  // The top pointer of each bank is tied to the bank base
  function automatic logic isFixedPtr(input logic [IDX_W-1:0] idx);
    return (int'(idx) % PER_BANK) == (PER_BANK - 1);
  endfunction

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import ptr_agu_pkg::*;
(
  input  logic             opValid,
  input  logic [IDX_W-1:0] opPtrIdx,
  input  logic [MOD_W-1:0] opMod,
  input  logic             ldValid,
  input  logic [IDX_W-1:0] ldIdx,
  output agu_ctl_t         ctl
);

  logic opFixed;
  logic wantInc;
  logic wantDec;

  always_comb begin
    opFixed = isFixedPtr(opPtrIdx);
    wantInc = (ptr_mod_e'(opMod) == MOD_STEP_UP) || (ptr_mod_e'(opMod) == MOD_STEP_UP2);
    wantDec = (ptr_mod_e'(opMod) == MOD_STEP_DN);
  end

  for (genvar i = 0; i < NUM_PTRS; i++) begin : g_strobe
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    localparam bit FIXED = ((i % PER_BANK) == (PER_BANK - 1));
    if (FIXED) begin : g_fixed
      assign ctl.loadEn[i] = 1'b0;
      assign ctl.incEn[i]  = 1'b0;
      assign ctl.decEn[i]  = 1'b0;
    end else begin : g_mod
      logic hit;
      assign hit           = opValid && (opPtrIdx == MY_IDX);
      assign ctl.loadEn[i] = ldValid && (ldIdx == MY_IDX);
      assign ctl.incEn[i]  = hit && wantInc;
      assign ctl.decEn[i]  = hit && wantDec;
    end
  end

  assign ctl.issue     = opValid;
  assign ctl.useOffset = opFixed;
  assign ctl.selIdx    = opPtrIdx;
  assign ctl.offset    = opMod[OFS_W-1:0];

endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import ptr_agu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  agu_ctl_t          ctl,
  input  logic [PTR_W-1:0]  ldData,
  output logic              addrValid,
  output logic [BANK_W-1:0] addrBank,
  output logic [PTR_W-1:0]  addrOut
);

  logic [PTR_W-1:0] ptrQ [NUM_PTRS];
  logic [PTR_W-1:0] effAddr;
  logic [BANK_W-1:0] effBank;

  for (genvar i = 0; i < NUM_PTRS; i++) begin : g_ptr
    localparam bit FIXED = ((i % PER_BANK) == (PER_BANK - 1));
    if (FIXED) begin : g_base
      assign ptrQ[i] = '0;
    end else begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                ptrQ[i] <= '0;
        else if (ctl.loadEn[i])   ptrQ[i] <= ldData;
        else if (ctl.incEn[i])    ptrQ[i] <= ptrQ[i] + PTR_W'(1);
        else if (ctl.decEn[i])    ptrQ[i] <= ptrQ[i] - PTR_W'(1);
      end
    end
  end

  always_comb begin
    effAddr = ctl.useOffset ? PTR_W'(ctl.offset) : ptrQ[ctl.selIdx];
    effBank = BANK_W'(int'(ctl.selIdx) / PER_BANK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrValid <= 1'b0;
      addrBank  <= '0;
      addrOut   <= '0;
    end else begin
      addrValid <= ctl.issue;
      if (ctl.issue) begin
        addrBank <= effBank;
        addrOut  <= effAddr;
      end
    end
  end

endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
  import ptr_agu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [2:0]       opPtrIdx,
  input  logic [1:0]       opMod,
  input  logic             ldValid,
  input  logic [2:0]       ldIdx,
  input  logic [7:0]       ldData,
  output logic             addrValid,
  output logic             addrBank,
  output logic [7:0]       addrOut
);

  agu_ctl_t ctl;

  agu_ctrl u_ctrl (
    .opValid  (opValid),
    .opPtrIdx (opPtrIdx),
    .opMod    (opMod),
    .ldValid  (ldValid),
    .ldIdx    (ldIdx),
    .ctl      (ctl)
  );

  agu_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .ldData    (ldData),
    .addrValid (addrValid),
    .addrBank  (addrBank),
    .addrOut   (addrOut)
  );

endmodule

// File: rtl/agu_checker.sv
module agu_checker
  import ptr_agu_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       opValid,
  input logic [2:0] opPtrIdx,
  input logic [1:0] opMod,
  input logic       ldValid,
  input logic [2:0] ldIdx,
  input logic [7:0] ldData,
  input logic       addrValid,
  input logic       addrBank,
  input logic [7:0] addrOut
);

  // R1: reset holds the valid flag low
  always @(posedge clk) begin
    if (!rstN) p_reset_idle_r1: assert (!addrValid);
  end

  // R2
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> addrValid);
  p_idle_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !addrValid);

  // R3
  p_bank_by_index_r3: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> (addrBank == $past(opPtrIdx[2])));

  // R7
  p_fixed_offset_r7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && isFixedPtr(opPtrIdx)) |=> (addrOut == {6'b0, $past(opMod)}));

  // R5: back-to-back up steps on one pointer advance the address by one
  p_step_up_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !isFixedPtr(opPtrIdx) && opMod[0] && !(ldValid && ldIdx == opPtrIdx))
    ##1 (opValid && opPtrIdx == $past(opPtrIdx))
    |=> (addrOut == $past(addrOut) + 8'd1));

  // R5: back-to-back down steps retreat by one
  p_step_down_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !isFixedPtr(opPtrIdx) && opMod == 2'b10 && !(ldValid && ldIdx == opPtrIdx))
    ##1 (opValid && opPtrIdx == $past(opPtrIdx))
    |=> (addrOut == $past(addrOut) - 8'd1));

  // R4: load then access returns the loaded value
  p_load_visible_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && !isFixedPtr(ldIdx) && !(opValid && opPtrIdx == ldIdx))
    ##1 (opValid && opPtrIdx == $past(ldIdx) && !(ldValid && ldIdx == $past(ldIdx)))
    |=> (addrOut == $past(ldData, 2)));

endmodule

bind ptr_addr_gen agu_checker u_chk (.*);

// File: tb/tb_ptr_addr_gen.sv
`timescale 1ns/1ps
module tb_ptr_addr_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [2:0] opPtrIdx = '0;
  logic [1:0] opMod = '0;
  logic       ldValid = 1'b0;
  logic [2:0] ldIdx = '0;
  logic [7:0] ldData = '0;
  logic       addrValid;
  logic       addrBank;
  logic [7:0] addrOut;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] mdl [8];

  always #2 clk = ~clk;

  ptr_addr_gen dut (.*);

  function automatic bit fixedIdx(input int i);
    return (i == 3) || (i == 7);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One cycle of stimulus; checks the registered result after the edge
  task automatic step(input bit doOp, input int idx, input int md,
                      input bit doLd, input int lIdx, input int lVal, input string req);
    int expAddr;
    @(negedge clk);
    opValid  = doOp;  opPtrIdx = 3'(idx); opMod = 2'(md);
    ldValid  = doLd;  ldIdx = 3'(lIdx);   ldData = 8'(lVal);
    expAddr  = fixedIdx(idx) ? md : int'(mdl[idx]);
    @(posedge clk); #1;
    chk(addrValid == doOp, {req, "/R2 valid"}, addrValid, doOp);
    if (doOp) begin
      chk(addrBank == (idx >= 4), {req, "/R3 bank"}, addrBank, idx >= 4);
      chk(addrOut == 8'(expAddr), req, addrOut, expAddr);
      if (!fixedIdx(idx)) begin
        if (md == 1 || md == 3) mdl[idx] = mdl[idx] + 8'd1;
        else if (md == 2)       mdl[idx] = mdl[idx] - 8'd1;
      end
    end
    if (doLd && !fixedIdx(lIdx)) mdl[lIdx] = 8'(lVal);
  endtask

  initial begin
    #800000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int vals [7] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF, 8'h5A};
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 chk(addrValid == 1'b0, "R1 valid in reset", addrValid, 0);
    @(negedge clk); rstN = 1'b1;
    // R1: each writable pointer reads 0 after reset
    for (int i = 0; i < 8; i++) step(1, i, 0, 0, 0, 0, "R1 reset pointer");
    step(0, 0, 0, 0, 0, 0, "R2 idle");

    // Sweep: load (R4/R8), access with each modifier (R5/R6/R7)
    for (int i = 0; i < 8; i++)
      for (int m = 0; m < 4; m++)
        foreach (vals[v]) begin
          step(0, 0, 0, 1, i, vals[v], "R4 load");
          step(1, i, m, 0, 0, 0, fixedIdx(i) ? "R7/R8 fixed offset" : "R4/R5 access");
          step(1, i, 0, 0, 0, 0, fixedIdx(i) ? "R7 fixed hold" : "R5/R6 after modify");
        end

    // R6: explicit wrap cases
    step(0, 0, 0, 1, 5, 8'hFF, "R6 setup");
    step(1, 5, 1, 0, 0, 0, "R6 wrap up pre");
    step(1, 5, 0, 0, 0, 0, "R6 wrap up result");
    step(0, 0, 0, 1, 2, 8'h00, "R6 setup");
    step(1, 2, 2, 0, 0, 0, "R6 wrap down pre");
    step(1, 2, 0, 0, 0, 0, "R6 wrap down result");

    // R5: runs of back-to-back steps
    for (int k = 0; k < 5; k++) step(1, 1, 3, 0, 0, 0, "R5 run up");
    for (int k = 0; k < 5; k++) step(1, 6, 2, 0, 0, 0, "R5 run down");

    // R9: same-cycle load and access on one pointer
    for (int m = 0; m < 4; m++) begin
      step(0, 0, 0, 1, 4, 8'h40, "R9 setup");
      step(1, 4, m, 1, 4, 8'hC3, "R9 old value used");
      step(1, 4, 0, 0, 0, 0, "R9 load wins");
    end

    // R10: load and access to different pointers in one cycle
    step(0, 0, 0, 1, 0, 8'h10, "R10 setup");
    step(1, 0, 1, 1, 6, 8'h99, "R10 access");
    step(1, 0, 0, 0, 0, 0, "R10 stepped pointer");
    step(1, 6, 0, 0, 0, 0, "R10 loaded pointer");

    // R8: load to fixed pointer in same cycle as its access
    step(1, 7, 2, 1, 7, 8'hEE, "R8 fixed load ignored");
    step(1, 7, 1, 0, 0, 0, "R8 fixed after load");
    step(1, 3, 3, 1, 3, 8'h77, "R8 fixed load ignored");
    step(1, 3, 0, 0, 0, 0, "R8 fixed after load");
    step(0, 0, 0, 0, 0, 0, "R2 idle end");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule